// File: doc/BRIEF.md
# Two-Vector Scan Chain with Output Hold Stages

This block is a chain of scan cells for delay testing. Each cell pairs a scan flip-flop with a hold stage. The scan flip-flop has a multiplexer on its data input. The hold stage sits between the flip-flop and the logic under test, so the logic sees only the hold stage outputs.

While a new pattern moves through the flip-flops, the hold stages keep the previous pattern applied to the logic. The logic inputs therefore do not change during shifting. An update pulse copies the whole shifted pattern into the hold stages in one edge. That edge launches the second vector of any chosen pair. The next edge, taken with scan enable low, captures the logic's response into the flip-flops. The response is then shifted out serially.

Each cell works in one of two modes:
- CELL_SHIFT, selected by scan enable high: the flip-flop takes the bit from its upstream neighbour.
- CELL_CAPTURE, selected by scan enable low: the flip-flop takes its functional data input.

Each hold stage also works in one of two modes:
- STAGE_LOAD, selected by update high.
- STAGE_KEEP, selected by update low.

For plain functional operation, update is held high.

Top module: `enhanced_scan_chain`

## Requirements
- R1: A rising clock edge with rst_n low sets every flip-flop and every hold output to 0, so hold_q and scan_out read 0 afterwards.
- R2: With scan_en high, an edge moves the chain by one place. Cell 0 takes scan_in and cell i takes the old value of cell i-1.
- R3: scan_out shows the last cell (index CHAIN_LEN-1). A bit shifted in first appears at scan_out after CHAIN_LEN shift edges. A value whose bit k should sit in cell k is therefore shifted in from bit CHAIN_LEN-1 down to bit 0.
- R4: With scan_en low, an edge loads func_d[i] into flip-flop i.
- R5: With upd low, hold_q keeps its value across any number of shift or capture edges.
- R6: With upd high, an edge loads hold_q with the flip-flop contents present just before that edge, whatever scan_en is.
- R7: A first vector held in hold_q stays applied while a second vector is shifted in. An update edge then switches hold_q directly from the first vector to the second, with no value in between.
- R8: An edge with upd high and scan_en low launches the held flip-flop pattern onto hold_q. In the same edge, the flip-flops capture func_d, which is still the response to the old hold_q. The following capture edge records the response to the launched vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | 1 = shift the chain, 0 = capture func_d |
| scan_in | input | 1 | Serial input to cell 0 |
| upd | input | 1 | 1 = hold stages load the flip-flop contents, 0 = hold stages keep their value |
| func_d | input | CHAIN_LEN | Functional data, one bit per cell |
| hold_q | output | CHAIN_LEN | Hold stage outputs that drive the logic under test |
| scan_out | output | 1 | Serial output from the last cell |

## Verification
The bound checker checks four rules on every cycle:
- the reset clear;
- the one-place shift;
- the parallel capture;
- the two hold stage rules: hold_q is frozen when upd is low, and hold_q takes the pre-edge flip-flop contents when upd is high.

Only the bench's scenarios can show the complete two-vector sequence. They need a logic model placed around the chain, so that the response captured after a launch can be traced back to the second vector rather than the first. The same is true of serial ordering at scan_out, because it is only visible after a whole unload.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic {
        CELL_CAPTURE = 1'b0,
        CELL_SHIFT   = 1'b1
    } cell_mode_e;

    typedef enum logic {
        STAGE_KEEP = 1'b0,
        STAGE_LOAD = 1'b1
    } stage_mode_e;
endpackage

// File: rtl/esc_scan_cell.sv
module esc_scan_cell
    import esc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic ser_in,
    input  logic func_in,
    output logic q
);
    cell_mode_e mode;
    logic       d_next;

    always_comb begin
        mode = cell_mode_e'(scan_en);
        unique case (mode)
            CELL_SHIFT:   d_next = ser_in;
            CELL_CAPTURE: d_next = func_in;
            default:      d_next = func_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d_next;
    end
endmodule

// File: rtl/esc_hold_stage.sv
module esc_hold_stage
    import esc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic src,
    output logic q
);
    stage_mode_e mode;
    logic        q_next;

    always_comb begin
        mode = stage_mode_e'(upd);
        unique case (mode)
            STAGE_LOAD: q_next = src;
            STAGE_KEEP: q_next = q;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end
endmodule

// File: rtl/enhanced_scan_chain.sv
module enhanced_scan_chain #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic                 scan_in,
    input  logic                 upd,
    input  logic [CHAIN_LEN-1:0] func_d,
    output logic [CHAIN_LEN-1:0] hold_q,
    output logic                 scan_out
);
    localparam int LAST = CHAIN_LEN - 1;

    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] ser_src;

    assign ser_src = {chain_q[LAST-1:0], scan_in};

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        esc_scan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .scan_en (scan_en),
            .ser_in  (ser_src[i]),
            .func_in (func_d[i]),
            .q       (chain_q[i])
        );

        esc_hold_stage u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (upd),
            .src   (chain_q[i]),
            .q     (hold_q[i])
        );
    end

    assign scan_out = chain_q[LAST];
endmodule

// File: rtl/esc_chain_checker.sv
module esc_chain_checker #(
    parameter int CHAIN_LEN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scan_en,
    input logic                 scan_in,
    input logic                 upd,
    input logic [CHAIN_LEN-1:0] func_d,
    input logic [CHAIN_LEN-1:0] chain_q,
    input logic [CHAIN_LEN-1:0] hold_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (chain_q == '0 && hold_q == '0));

    a_r2_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> chain_q == {$past(chain_q[CHAIN_LEN-2:0]), $past(scan_in)});

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> chain_q == $past(func_d));

    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(hold_q));

    a_r6_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> hold_q == $past(chain_q));
endmodule

bind enhanced_scan_chain esc_chain_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .scan_in (scan_in),
    .upd     (upd),
    .func_d  (func_d),
    .chain_q (chain_q),
    .hold_q  (hold_q)
);

// File: tb/tb_enhanced_scan_chain.sv
module tb_enhanced_scan_chain;
    localparam int N = 8;
    localparam int NV = 4;
    localparam logic [N-1:0] V1S [NV] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
    localparam logic [N-1:0] V2S [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h3C};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         upd = 1'b0;
    logic [N-1:0] func_d;
    logic [N-1:0] hold_q;
    logic         scan_out;
    logic         ovr_en = 1'b0;
    logic [N-1:0] ovr_val = '0;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 0;

    always #4 clk = ~clk;

    function automatic logic [N-1:0] lut_f(input logic [N-1:0] v);
        return v ^ {v[N-2:0], v[N-1]} ^ 8'h3C;
    endfunction

    assign func_d = ovr_en ? ovr_val : lut_f(hold_q);

    enhanced_scan_chain #(.CHAIN_LEN(N)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .upd      (upd),
        .func_d   (func_d),
        .hold_q   (hold_q),
        .scan_out (scan_out)
    );

    task automatic step(input logic se, input logic si, input logic up);
        @(negedge clk);
        scan_en = se; scan_in = si; upd = up;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [N-1:0] v, input logic watch, input logic [N-1:0] held);
        for (int k = N - 1; k >= 0; k--) begin
            step(1'b1, v[k], 1'b0);
            if (watch) chk("R5 hold during shift", hold_q, held);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [N-1:0] r;
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R1 reset hold_q", hold_q, '0);
        chk("R1 reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);
        @(negedge clk) rst_n = 1'b1;

        for (int e = 0; e < NV; e++) begin
            load(V1S[e], 1'b0, '0);
            step(1'b0, 1'b0, 1'b1);
            chk("R6 update V1", hold_q, V1S[e]);
            load(V2S[e], 1'b1, V1S[e]);
            step(1'b0, 1'b0, 1'b1);
            chk("R7 launch V2", hold_q, V2S[e]);
            step(1'b0, 1'b0, 1'b0);
            r = lut_f(V2S[e]);
            for (int k = N - 1; k >= 0; k--) begin
                chk("R8 R3 response bit", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, r[k]});
                step(1'b1, 1'b0, 1'b0);
            end
            chk("R5 hold after unload", hold_q, V2S[e]);
        end

        ovr_en = 1'b1; ovr_val = 8'hC3;
        step(1'b0, 1'b0, 1'b0);
        chk("R5 capture leaves hold", hold_q, V2S[NV-1]);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk("R4 R2 capture then shifts", hold_q, 8'h87);
        step(1'b0, 1'b0, 1'b1);
        chk("R2 second shift visible", hold_q, 8'h0E);
        step(1'b0, 1'b0, 1'b1);
        chk("R4 capture visible", hold_q, 8'hC3);
        ovr_en = 1'b0;

        load(8'h01, 1'b0, '0);
        for (int k = 0; k < N - 1; k++) begin
            chk("R3 bit not yet out", {{(N-1){1'b0}}, scan_out}, '0);
            step(1'b1, 1'b0, 1'b0);
        end
        chk("R3 first bit reaches scan_out", {{(N-1){1'b0}}, scan_out}, 8'h01);

        load(8'hFF, 1'b0, '0);
        step(1'b1, 1'b0, 1'b1);
        chk("R1 pre-reset hold", hold_q, 8'hFF);
        @(negedge clk) rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0);
        chk("R1 mid-run reset hold_q", hold_q, '0);
        chk("R1 mid-run reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);
        @(negedge clk) rst_n = 1'b1;

        finish_run();
    end
endmodule